// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Slave

This block is a standard-mode I2C slave that holds a small bank of seven 8-bit configuration registers for a clock-generation subsystem. The host writes with address byte 0xD2 and reads with 0xD3; no other addresses, general call or 10-bit addressing are recognised. Only block transfers are supported. A write carries a command byte and a count byte whose values are thrown away, and then data that always lands from register 0 upward. A read first returns the number of implemented registers and then the registers in ascending order.

SCL and SDA are sampled into the system clock. The system clock must run at least eight times faster than the bus bit rate, which is 100 kbit/s or less. START and STOP are recognised from SDA edges while SCL is high. A START seen in the middle of a transfer simply opens a new transfer.

The SDA pad is open-drain and sits outside the block. The block receives the resolved line level on `sda_i` and asks for a low level with `sda_pull_low`. Register 0 is decoded into the frequency-select override, the spread-spectrum controls and the global output tristate. The other registers are per-output enable masks, and they leave the block as a flat vector.

Top module: `blkcfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00, registers 1 to 6 hold 0xFF, and `sda_pull_low` is 0.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no ACK, and the slave then ignores the bus until the next START or STOP.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. The third byte is stored into register 0, the fourth into register 1, and so on.
- R4: The slave pulls SDA low during the ninth SCL pulse after every byte of an addressed write: the address, the command byte, the count byte and every data byte.
- R5: A STOP after any complete data byte keeps every byte already received. A data byte cut short by STOP is not stored, and its register keeps its old value.
- R6: Data bytes past register 6 are acknowledged and discarded. They do not wrap to register 0.
- R7: A read returns the byte count 0x07 first, then registers 0 to 6, each most significant bit first. Any byte past register 6 reads as 0x00. Each byte is followed by a host acknowledge slot.
- R8: A host NACK ends a read. The slave then drives SDA no more until the next START.
- R9: Register 0 decodes as follows: bit 0 is `outputs_off`, bit 1 is `spread_on`, bit 2 is `spread_down`, bit 3 is `sel_from_reg`, bits 6:4 are `sel_code` and bit 7 is `factory_test`. `cfg_bytes[8k+7:8k]` carries register k.
- R10: A START inside a transfer begins a fresh transfer. The address is decoded again, and write data restarts at register 0 after the two header bytes.
- R11: The slave begins to pull SDA low only while SCL is low. Register contents change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Resolved bus data line level |
| sda_pull_low | output | 1 | Request for the open-drain pad to pull SDA low |
| cfg_bytes | output | 56 | All registers; register k in bits [8k+7:8k] |
| sel_from_reg | output | 1 | Frequency select taken from `sel_code` rather than straps |
| sel_code | output | 3 | Register-programmed frequency select code |
| spread_down | output | 1 | 1 = down spread, 0 = center spread |
| spread_on | output | 1 | Spread-spectrum modulation enable |
| outputs_off | output | 1 | Tristate all clock outputs |
| factory_test | output | 1 | Register 0 bit 7, 0 in normal operation |

## Verification
The bench sweeps register 0 across a spread of values and drives full block writes, both with and without overrun. A design that let the header bytes through would shift every register by two places. One that wrapped its pointer would overwrite register 0 with the eighth data byte. Truncated bytes followed by STOP, unknown and near-miss addresses, and repeated STARTs into both writes and reads are also covered; getting these wrong shows up as a corrupted register, a stray ACK, or data continuing from the wrong index. Reads are checked for the leading count, zero fill past the bank, and silence after a NACK. A slave that kept transmitting after the NACK would pull the line during a byte that should read back as 0xFF.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;

    // Default sizing and addressing.
    localparam int          CFG_REGS_DEF = 7;
    localparam logic [6:0]  BUS_ADDR_DEF = 7'h69;   // 0xD2 write / 0xD3 read
    localparam int          SYNC_DEF     = 2;

    // Link-layer protocol states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_t;

    // Register 0 layout; bit positions are decoded by the clock core.
    typedef struct packed {
        logic       factory_test;   // bit 7
        logic [2:0] sel_code;       // bits 6:4
        logic       sel_from_reg;   // bit 3
        logic       spread_down;    // bit 2
        logic       spread_on;      // bit 1
        logic       outputs_off;    // bit 0
    } ctrl_byte_t;

    // Power-on value of register idx.
    function automatic logic [7:0] cfg_reset_byte(input int idx);
        return (idx == 0) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/blkcfg_bus_sync.sv
module blkcfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_lvl;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chain; its length is chosen by STAGES.
    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_pipe <= 1'b1;
                sda_pipe <= 1'b1;
            end else begin
                scl_pipe <= scl_in;
                sda_pipe <= sda_in;
            end
        end
    end else begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_pipe <= '1;
                sda_pipe <= '1;
            end else begin
                scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            end
        end
    end

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  =  scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl &  scl_q;
    assign start_evt =  scl_lvl &  scl_q &  sda_q & ~sda_lvl;
    assign stop_evt  =  scl_lvl &  scl_q & ~sda_q &  sda_lvl;

endmodule

// File: rtl/blkcfg_link.sv
module blkcfg_link
    import blkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = BUS_ADDR_DEF,
    parameter int         NREG     = CFG_REGS_DEF,
    localparam int        WPW      = $clog2(NREG + 3),
    localparam int        RDW      = $clog2(NREG + 2),
    localparam int        IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_evt,
    input  logic            stop_evt,
    output logic            sda_pull,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_sel,
    output logic [7:0]      wr_data,
    output logic [RDW-1:0]  rd_sel,
    input  logic [7:0]      rd_data
);

    // Write position: 0 = command, 1 = count, 2.. = data, saturating.
    localparam logic [WPW-1:0] WP_DATA0 = WPW'(2);
    localparam logic [WPW-1:0] WP_END   = WPW'(NREG + 2);
    // Read position: 0 = count, 1..NREG = registers, NREG+1 = zero fill.
    localparam logic [RDW-1:0] RD_LAST  = RDW'(NREG + 1);

    link_state_t      state;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic             addr_phase;
    logic             rd_mode;
    logic             mst_ack;
    logic [WPW-1:0]   wr_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            mst_ack    <= 1'b0;
            wr_pos     <= '0;
            rd_sel     <= '0;
            sda_pull   <= 1'b0;
            wr_en      <= 1'b0;
            wr_sel     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state      <= ST_RX;
                addr_phase <= 1'b1;
                bitcnt     <= '0;
                sda_pull   <= 1'b0;
                wr_pos     <= '0;
                rd_sel     <= '0;
            end else if (stop_evt) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (addr_phase) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    rd_mode  <= shreg[0];
                                    state    <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                state    <= ST_RX_ACK;
                                if (wr_pos >= WP_DATA0 && wr_pos < WP_END) begin
                                    wr_en   <= 1'b1;
                                    wr_sel  <= IDXW'(wr_pos - WP_DATA0);
                                    wr_data <= shreg;
                                end
                                if (wr_pos != WP_END) begin
                                    wr_pos <= wr_pos + WPW'(1);
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            addr_phase <= 1'b0;
                            bitcnt     <= '0;
                            if (addr_phase && rd_mode) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                bitcnt   <= 4'd1;
                                state    <= ST_TX;
                                if (rd_sel != RD_LAST) begin
                                    rd_sel <= rd_sel + RDW'(1);
                                end
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                sda_pull <= ~shreg[6];
                                shreg    <= {shreg[6:0], 1'b0};
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                bitcnt   <= 4'd1;
                                state    <= ST_TX;
                                if (rd_sel != RD_LAST) begin
                                    rd_sel <= rd_sel + RDW'(1);
                                end
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/blkcfg_regbank.sv
module blkcfg_regbank
    import blkcfg_pkg::*;
#(
    parameter int  NREG = CFG_REGS_DEF,
    localparam int RDW  = $clog2(NREG + 2),
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [RDW-1:0]    rd_sel,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_flat
);

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= cfg_reset_byte(g);
            end else if (wr_en && wr_sel == IDXW'(g)) begin
                regs[g] <= wr_data;
            end
        end
        assign cfg_flat[g*8 +: 8] = regs[g];
    end

    // Read slot 0 is the byte count; slots past the bank read zero.
    always_comb begin
        rd_data = 8'h00;
        if (rd_sel == '0) begin
            rd_data = 8'(NREG);
        end
        for (int k = 0; k < NREG; k++) begin
            if (rd_sel == RDW'(k + 1)) begin
                rd_data = regs[k];
            end
        end
    end

endmodule

// File: rtl/blkcfg_i2c_slave.sv
module blkcfg_i2c_slave
    import blkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = BUS_ADDR_DEF,
    parameter int         NREG        = CFG_REGS_DEF,
    parameter int         SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_low,
    output logic [NREG*8-1:0] cfg_bytes,
    output logic              sel_from_reg,
    output logic [2:0]        sel_code,
    output logic              spread_down,
    output logic              spread_on,
    output logic              outputs_off,
    output logic              factory_test
);

    localparam int RDW  = $clog2(NREG + 2);
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

    logic            sda_lvl;
    logic            scl_rise;
    logic            scl_fall;
    logic            start_evt;
    logic            stop_evt;
    logic            wr_en;
    logic [IDXW-1:0] wr_sel;
    logic [7:0]      wr_data;
    logic [RDW-1:0]  rd_sel;
    logic [7:0]      rd_data;
    ctrl_byte_t      ctrl;

    blkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    blkcfg_link #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_link (
        .clk       (clk),
        .rst       (rst),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_pull  (sda_pull_low),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    blkcfg_regbank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .cfg_flat (cfg_bytes)
    );

    assign ctrl         = ctrl_byte_t'(cfg_bytes[7:0]);
    assign sel_from_reg = ctrl.sel_from_reg;
    assign sel_code     = ctrl.sel_code;
    assign spread_down  = ctrl.spread_down;
    assign spread_on    = ctrl.spread_on;
    assign outputs_off  = ctrl.outputs_off;
    assign factory_test = ctrl.factory_test;

endmodule

// File: rtl/blkcfg_checker.sv
module blkcfg_checker
    import blkcfg_pkg::*;
#(
    parameter int NREG = CFG_REGS_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_pull_low,
    input logic [NREG*8-1:0] cfg_bytes
);

    // R1: each register holds its power-on value one cycle after reset.
    for (genvar g = 0; g < NREG; g++) begin : g_rstchk
        assert_reset_image_R1: assert property (@(posedge clk)
            rst |=> (cfg_bytes[g*8 +: 8] == cfg_reset_byte(g)));
    end

    // R1: the bus line is released coming out of reset.
    assert_release_after_reset_R1: assert property (@(posedge clk)
        rst |=> !sda_pull_low);

    // R11: the slave starts pulling SDA only in the SCL low phase.
    assert_drive_in_low_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_low) |-> !scl_i);

    // R11, R5: registers update only in the SCL low phase, never on STOP.
    assert_update_in_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bytes) |-> !scl_i);

endmodule

bind blkcfg_i2c_slave blkcfg_checker #(.NREG(NREG)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .sda_pull_low (sda_pull_low),
    .cfg_bytes    (cfg_bytes)
);

// File: tb/test_blkcfg_i2c_slave.sv
module test_blkcfg_i2c_slave;
    import blkcfg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;     // system clocks per quarter bit
    localparam int NREG       = CFG_REGS_DEF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_bus;
    logic              sda_pull_low;
    logic [NREG*8-1:0] cfg_bytes;
    logic              sel_from_reg;
    logic [2:0]        sel_code;
    logic              spread_down;
    logic              spread_on;
    logic              outputs_off;
    logic              factory_test;

    int         n_cmp = 0;
    int         n_bad = 0;
    int         pull_cycles = 0;
    logic [7:0] exp_regs [NREG];
    logic [7:0] wbuf [16];

    assign sda_bus = sda_m & ~sda_pull_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (sda_pull_low) pull_cycles++;

    blkcfg_i2c_slave i_blkcfg_i2c_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_low (sda_pull_low),
        .cfg_bytes    (cfg_bytes),
        .sel_from_reg (sel_from_reg),
        .sel_code     (sel_code),
        .spread_down  (spread_down),
        .spread_on    (spread_on),
        .outputs_off  (outputs_off),
        .factory_test (factory_test)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            d = {d[6:0], sda_bus}; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // START, write address, dummy command and count, then wbuf[0..n-1]; no STOP.
    task automatic write_block(input int ndata, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte(8'hD2, a); acks += int'(a);
        send_byte(8'hA5, a); acks += int'(a);
        send_byte(8'h3C, a); acks += int'(a);
        for (int k = 0; k < ndata; k++) begin
            send_byte(wbuf[k], a); acks += int'(a);
            if (k < NREG) exp_regs[k] = wbuf[k];
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NREG; k++)
            chk(req, $sformatf("reg%0d", k), 32'(cfg_bytes[k*8 +: 8]), 32'(exp_regs[k]));
    endtask

    task automatic check_fields(input string req);
        chk(req, "outputs_off",  32'(outputs_off),  32'(exp_regs[0][0]));
        chk(req, "spread_on",    32'(spread_on),    32'(exp_regs[0][1]));
        chk(req, "spread_down",  32'(spread_down),  32'(exp_regs[0][2]));
        chk(req, "sel_from_reg", 32'(sel_from_reg), 32'(exp_regs[0][3]));
        chk(req, "sel_code",     32'(sel_code),     32'(exp_regs[0][6:4]));
        chk(req, "factory_test", 32'(factory_test), 32'(exp_regs[0][7]));
    endtask

    // Full read of nbytes after the count; the last byte gets a NACK.
    task automatic read_check(input string req, input int nbytes);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD3, a);
        chk("R2", "read address ack", 32'(a), 32'd1);
        recv_byte(1'b1, d);
        chk(req, "byte count", 32'(d), 32'd7);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k != nbytes - 1, d);
            chk(req, $sformatf("read slot %0d", k), 32'(d),
                32'(k < NREG ? exp_regs[k] : 8'h00));
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int acks;
        int pc;
        logic a;
        logic [7:0] d;

        for (int k = 0; k < NREG; k++) exp_regs[k] = (k == 0) ? 8'h00 : 8'hFF;
        tick(6);
        rst = 1'b0;
        tick(4);

        // R1: power-on image and released line
        check_regs("R1");
        chk("R1", "sda_pull_low after reset", 32'(sda_pull_low), 32'd0);
        check_fields("R9");

        // R7: readback of the reset image, with zero fill past the bank
        read_check("R7", NREG + 2);

        // R3, R4, R6: full block plus two overrun bytes
        for (int k = 0; k < NREG + 2; k++) wbuf[k] = 8'(k * 41 + 19);
        write_block(NREG + 2, acks);
        bus_stop();
        chk("R4", "acks on write", 32'(acks), 32'(NREG + 5));
        check_regs("R3");
        chk("R6", "reg0 not wrapped", 32'(cfg_bytes[7:0]), 32'(wbuf[0]));
        read_check("R7", NREG);

        // R9: sweep of register 0
        for (int v = 0; v < 256; v += 15) begin
            wbuf[0] = 8'(v);
            write_block(1, acks);
            bus_stop();
            chk("R4", "acks single write", 32'(acks), 32'd4);
            check_fields("R9");
        end
        check_regs("R9");

        // R5: STOP after two complete bytes keeps them, leaves the rest
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_block(2, acks);
        bus_stop();
        check_regs("R5");
        // R5: a byte cut after five bits is dropped
        wbuf[0] = 8'h77;
        write_block(1, acks);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop();
        check_regs("R5");
        chk("R5", "reg1 untouched by partial byte", 32'(cfg_bytes[15:8]), 32'h22);

        // R2, R11: foreign addresses get no ACK and no drive at all
        foreach (wbuf[i]) wbuf[i] = 8'h00;
        pc = pull_cycles;
        bus_start();
        send_byte(8'hD4, a);
        chk("R2", "no ack for 0xD4", 32'(a), 32'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        chk("R2", "no ack after foreign address", 32'(a), 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'hA2, a);
        chk("R2", "no ack for 0xA2", 32'(a), 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        chk("R2", "no ack for 0xD0", 32'(a), 32'd0);
        bus_stop();
        chk("R11", "no pull during foreign transfers", 32'(pull_cycles - pc), 32'd0);
        check_regs("R2");

        // R10: repeated START restarts a write at register 0
        wbuf[0] = 8'h44;
        write_block(1, acks);
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        write_block(2, acks);
        bus_stop();
        chk("R10", "acks after repeated start", 32'(acks), 32'd5);
        check_regs("R10");
        // R10: repeated START from a write into a read
        wbuf[0] = 8'h99;
        write_block(1, acks);
        bus_start();
        send_byte(8'hD3, a);
        chk("R10", "read address ack after restart", 32'(a), 32'd1);
        recv_byte(1'b1, d);
        chk("R10", "count after restart", 32'(d), 32'd7);
        recv_byte(1'b1, d);
        chk("R10", "reg0 after restart", 32'(d), 32'h99);
        recv_byte(1'b0, d);
        chk("R10", "reg1 after restart", 32'(d), 32'h66);
        bus_stop();

        // R8: NACK on the count byte; the next clocked byte must float high
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, d);
        chk("R8", "count before nack", 32'(d), 32'd7);
        pc = pull_cycles;
        recv_byte(1'b0, d);
        chk("R8", "line floats after nack", 32'(d), 32'hFF);
        chk("R8", "no pull after nack", 32'(pull_cycles - pc), 32'd0);
        bus_stop();
        chk("R8", "released after stop", 32'(sda_pull_low), 32'd0);

        summary();
        $finish;
    end

endmodule